// File: doc/BRIEF.md
# Auto-Incrementing Register Pointer File

This block is the byte-level register access layer of a small four-channel LED controller that sits behind a two-wire serial slave. A bus layer that has already decoded bits and framing hands it one-cycle event pulses: start (including repeated start), address byte received, data byte written, data byte consumed by a read, and stop. Each byte travels on a shared 8-bit input.

The block compares the address byte against its 7-bit slave address, which a build-time variant bit chooses. On a write transfer, the first data byte goes into a control register. That byte supplies a 3-bit register pointer and an auto-increment flag. Every later data byte is written to the register the pointer selects. On a read transfer, the byte at the current pointer is presented continuously on the transmit output. Each read pulse marks that byte as sent.

When the flag is set, the pointer steps after every data byte, in both directions. It wraps through the unused codes back to zero. Register zero is a read-only image of the four LED pins, taken through a two-flop synchronizer. The remaining registers drive the blink and selector logic downstream.

Top module: `ledPtrRegFile`

## Requirements
- R1: `addrAck` is high exactly in a cycle where `evAddr` is high and `rxByte[7:1]` equals `{6'b110001, VARIANT}`. `rxByte[0]` selects the transfer type: 1 is read and 0 is write.
- R2: After a matched write address, the first `evWrite` byte loads the control register. Bits 2:0 are the pointer and bit 4 is the auto-increment flag. Bits 7:5 and bit 3 are stored as zero whatever was sent, so `ctrlOut` equals `rxByte & 8'h17`.
- R3: Later write bytes update the register at the pointer: 1 is prescaler 0, 2 is duty 0, 3 is prescaler 1, 4 is duty 1 and 5 is the LED selector. A read returns the same value on `txData`.
- R4: With the flag set, the pointer advances by one after each data byte written or read. With the flag clear, the pointer holds. No other control bit ever changes.
- R5: An auto-incrementing pointer steps 101 to 110 to 111, then wraps to 000.
- R6: A write byte at pointer 000 changes no register.
- R7: After reset, control is 00h, both prescalers are 00h, both duty registers are 80h and the LED selector is 00h.
- R8: At pointer 000, `txData` reads `{4'b0000, pins}`. A pin change is not visible one clock edge later but is visible after two.
- R9: Pointer codes 110 and 111 read 00h, and a write there changes no register.
- R10: A stop keeps the pointer and the control value. A read after a repeated start returns the register at the pointer left by the preceding write.
- R11: Write and read pulses that arrive after a non-matching address, or after a stop, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evStart | input | 1 | Start or repeated start pulse |
| evAddr | input | 1 | Address byte present on rxByte |
| evWrite | input | 1 | Written data byte present on rxByte |
| evRead | input | 1 | The byte on txData has been sent |
| evStop | input | 1 | Stop pulse |
| rxByte | input | 8 | Received byte |
| ledPins | input | 4 | Asynchronous LED pin levels |
| addrAck | output | 1 | Address matched, acknowledge |
| txData | output | 8 | Byte at the current pointer |
| ctrlOut | output | 8 | Control register |
| psc0Out | output | 8 | Prescaler 0 |
| pwm0Out | output | 8 | Duty 0 |
| psc1Out | output | 8 | Prescaler 1 |
| pwm1Out | output | 8 | Duty 1 |
| ledSelOut | output | 8 | LED selector |

## Verification
Assertions check the following on every cycle: pointer stepping and holding, the wrap from 111 to 000, that register contents stay frozen on writes at codes 000, 110 and 111, that the control byte is captured after a matched write address, and that all strobes are silent after a stop. The bench's scenarios show the rest: the full register map against a model, the exact cycle at which a pin change becomes visible, the reset values, and the pointer surviving a stop or repeated start into a read. Random transfers mix pointers, flag settings and burst lengths, and directed cases cover the wrap and the non-matching addresses.

// File: rtl/ledRegPkg.sv
package ledRegPkg;
  localparam int RegW = 8;
  localparam int PtrW = 3;
  localparam int NumCodes = 1 << PtrW;

  typedef struct packed {
    logic wrCtrl;
    logic wrData;
    logic advance;
  } strobeT;
endpackage

// File: rtl/ledRegCtrl.sv
module ledRegCtrl
  import ledRegPkg::*;
#(
  parameter logic VARIANT = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evStart,
  input  logic            evAddr,
  input  logic            evWrite,
  input  logic            evRead,
  input  logic            evStop,
  input  logic [RegW-1:0] rxByte,
  output logic            addrAck,
  output strobeT          strobe
);
  localparam logic [6:0] SlaveAddr = {6'b110001, VARIANT};

  logic selected, readMode, awaitCtrl, addrMatch, frameEnd;

  assign addrMatch = (rxByte[7:1] == SlaveAddr);
  assign frameEnd  = evStart | evStop;
  assign addrAck   = evAddr & addrMatch;

  always_comb begin
    strobe.wrCtrl  = evWrite & selected & ~readMode & awaitCtrl;
    strobe.wrData  = evWrite & selected & ~readMode & ~awaitCtrl;
    strobe.advance = (evWrite & selected & ~readMode & ~awaitCtrl)
                   | (evRead & selected & readMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selected  <= 1'b0;
      readMode  <= 1'b0;
      awaitCtrl <= 1'b0;
    end else if (frameEnd) begin
      selected  <= 1'b0;
      awaitCtrl <= 1'b0;
    end else if (evAddr) begin
      selected  <= addrMatch;
      readMode  <= rxByte[0];
      awaitCtrl <= addrMatch & ~rxByte[0];
    end else if (strobe.wrCtrl) begin
      awaitCtrl <= 1'b0;
    end
  end

  p_ctrl_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evAddr && addrMatch && !rxByte[0] && !frameEnd)
      ##1 (evWrite && !evAddr && !frameEnd) |-> strobe.wrCtrl);

  p_quiet_after_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    evStop |=> (strobe == '0));

  p_ack_needs_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> evAddr);
endmodule

// File: rtl/ledRegData.sv
module ledRegData
  import ledRegPkg::*;
#(
  parameter int              LedN   = 4,
  parameter logic [RegW-1:0] DutyRst = 8'h80
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          strobe,
  input  logic [RegW-1:0] rxByte,
  input  logic [LedN-1:0] ledPins,
  output logic [RegW-1:0] txData,
  output logic [RegW-1:0] ctrlOut,
  output logic [RegW-1:0] psc0Out,
  output logic [RegW-1:0] pwm0Out,
  output logic [RegW-1:0] psc1Out,
  output logic [RegW-1:0] pwm1Out,
  output logic [RegW-1:0] ledSelOut
);
  localparam logic [RegW-1:0] CtrlMask = 8'h17;
  localparam int LastReg = 5;

  logic [RegW-1:0] ctrlReg;
  logic [PtrW-1:0] ptr;
  logic            autoInc;
  logic [LedN-1:0] syncA, syncB;
  logic [RegW-1:0] regArr [NumCodes];

  assign ptr     = ctrlReg[PtrW-1:0];
  assign autoInc = ctrlReg[4];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strobe.wrCtrl) begin
      ctrlReg <= rxByte & CtrlMask;
    end else if (strobe.advance && autoInc) begin
      ctrlReg[PtrW-1:0] <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= ledPins;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < NumCodes; i++) begin : g_reg
    if (i == 0) begin : g_input
      assign regArr[i] = {{(RegW-LedN){1'b0}}, syncB};
    end else if (i <= LastReg) begin : g_store
      localparam logic [RegW-1:0] RstVal = (i == 2 || i == 4) ? DutyRst : '0;
      logic [RegW-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RstVal;
        else if (strobe.wrData && ptr == PtrW'(i)) q <= rxByte;
      end
      assign regArr[i] = q;
    end else begin : g_empty
      assign regArr[i] = '0;
    end
  end

  assign txData    = regArr[ptr];
  assign ctrlOut   = ctrlReg;
  assign psc0Out   = regArr[1];
  assign pwm0Out   = regArr[2];
  assign psc1Out   = regArr[3];
  assign pwm1Out   = regArr[4];
  assign ledSelOut = regArr[5];

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && autoInc && !strobe.wrCtrl && ptr != 3'd7)
      |=> (ptr == $past(ptr) + 3'd1) && (ctrlReg[7:3] == $past(ctrlReg[7:3])));

  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrCtrl && !(strobe.advance && autoInc)) |=> $stable(ctrlReg));

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && autoInc && !strobe.wrCtrl && ptr == 3'd7) |=> (ptr == 3'd0));

  p_input_ro_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrData && ptr == 3'd0)
      |=> $stable({psc0Out, pwm0Out, psc1Out, pwm1Out, ledSelOut}));

  p_high_codes_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrData && ptr >= 3'd6)
      |=> $stable({psc0Out, pwm0Out, psc1Out, pwm1Out, ledSelOut}));

  p_input_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ptr == 3'd0) |-> (txData[7:4] == 4'h0));
endmodule

// File: rtl/ledPtrRegFile.sv
module ledPtrRegFile
  import ledRegPkg::*;
#(
  parameter logic VARIANT = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       evStart,
  input  logic       evAddr,
  input  logic       evWrite,
  input  logic       evRead,
  input  logic       evStop,
  input  logic [7:0] rxByte,
  input  logic [3:0] ledPins,
  output logic       addrAck,
  output logic [7:0] txData,
  output logic [7:0] ctrlOut,
  output logic [7:0] psc0Out,
  output logic [7:0] pwm0Out,
  output logic [7:0] psc1Out,
  output logic [7:0] pwm1Out,
  output logic [7:0] ledSelOut
);
  strobeT strobe;

  ledRegCtrl #(.VARIANT(VARIANT)) u_ctrl (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evAddr(evAddr),
    .evWrite(evWrite), .evRead(evRead), .evStop(evStop),
    .rxByte(rxByte), .addrAck(addrAck), .strobe(strobe)
  );

  ledRegData #(.LedN(4), .DutyRst(8'h80)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .ledPins(ledPins), .txData(txData), .ctrlOut(ctrlOut),
    .psc0Out(psc0Out), .pwm0Out(pwm0Out), .psc1Out(psc1Out),
    .pwm1Out(pwm1Out), .ledSelOut(ledSelOut)
  );
endmodule

// File: tb/sim_ledPtrRegFile.sv
module sim_ledPtrRegFile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, evAddr = 0, evWrite = 0, evRead = 0, evStop = 0;
  logic [7:0] rxByte = 0;
  logic [3:0] ledPins = 0;
  logic addrAck;
  logic [7:0] txData, ctrlOut, psc0Out, pwm0Out, psc1Out, pwm1Out, ledSelOut;

  int total = 0, bad = 0;
  logic [7:0] mCtrl;
  logic [7:0] mReg [8];
  localparam logic [6:0] Me = 7'b1100010;

  always #10 clk = ~clk;

  ledPtrRegFile #(.VARIANT(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evAddr(evAddr),
    .evWrite(evWrite), .evRead(evRead), .evStop(evStop), .rxByte(rxByte),
    .ledPins(ledPins), .addrAck(addrAck), .txData(txData), .ctrlOut(ctrlOut),
    .psc0Out(psc0Out), .pwm0Out(pwm0Out), .psc1Out(psc1Out),
    .pwm1Out(pwm1Out), .ledSelOut(ledSelOut)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic [2:0] p);
    if (p == 3'd0) return {4'h0, ledPins};
    if (p <= 3'd5) return mReg[p];
    return 8'h00;
  endfunction

  task automatic stepPtr();
    if (mCtrl[4]) mCtrl[2:0] = mCtrl[2:0] + 3'd1;
  endtask

  task automatic pulse(input int kind, input logic [7:0] b);
    @(negedge clk);
    rxByte = b;
    case (kind)
      0: evStart = 1;
      1: evAddr = 1;
      2: evWrite = 1;
      3: evRead = 1;
      default: evStop = 1;
    endcase
    @(negedge clk);
    {evStart, evAddr, evWrite, evRead, evStop} = '0;
  endtask

  task automatic sendAddr(logic [6:0] a, logic rd, logic expAck, string req);
    @(negedge clk);
    rxByte = {a, rd};
    evAddr = 1;
    #1 chk(req, {7'd0, addrAck}, {7'd0, expAck});
    @(negedge clk);
    evAddr = 0;
  endtask

  task automatic wrByte(logic [7:0] b, logic isCtrl);
    pulse(2, b);
    if (isCtrl) mCtrl = b & 8'h17;
    else begin
      if (mCtrl[2:0] >= 3'd1 && mCtrl[2:0] <= 3'd5) mReg[mCtrl[2:0]] = b;
      stepPtr();
    end
  endtask

  task automatic rdByte(string req);
    @(negedge clk);
    chk(req, txData, expRead(mCtrl[2:0]));
    pulse(3, 8'h00);
    stepPtr();
  endtask

  task automatic checkAll(string req);
    @(negedge clk);
    chk({req, " ctrl"}, ctrlOut, mCtrl);
    chk({req, " psc0"}, psc0Out, mReg[1]);
    chk({req, " pwm0"}, pwm0Out, mReg[2]);
    chk({req, " psc1"}, psc1Out, mReg[3]);
    chk({req, " pwm1"}, pwm1Out, mReg[4]);
    chk({req, " sel"}, ledSelOut, mReg[5]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    mCtrl = 8'h00;
    mReg = '{8'h00, 8'h00, 8'h80, 8'h00, 8'h80, 8'h00, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R7 reset");

    // R1 non-matching addresses: other variant and unrelated
    pulse(0, 0);
    sendAddr(7'b1100011, 1'b0, 1'b0, "R1 other variant");
    wrByte(8'h15, 1'b0);
    mCtrl = 8'h00;
    mReg[5] = 8'h00;
    checkAll("R11 unmatched ignored");
    sendAddr(7'b0100010, 1'b0, 1'b0, "R1 unrelated");
    pulse(4, 0);

    // R2 mask of unused bits
    pulse(0, 0);
    sendAddr(Me, 1'b0, 1'b1, "R1 match");
    wrByte(8'hFD, 1'b1);
    checkAll("R2 mask");
    chk("R2 ctrl value", ctrlOut, 8'h15);
    // R3 write selector with AI on: pointer wraps through 6,7 to 0
    wrByte(8'hA5, 1'b0);
    chk("R4 step", ctrlOut, 8'h16);
    wrByte(8'h33, 1'b0);
    wrByte(8'h44, 1'b0);
    chk("R5 wrap", ctrlOut, 8'h10);
    checkAll("R9 high codes ignored");
    wrByte(8'h99, 1'b0);
    checkAll("R6 input write ignored");
    chk("R4 step after input", ctrlOut, 8'h11);
    pulse(4, 0);
    chk("R10 stop keeps ctrl", ctrlOut, 8'h11);
    pulse(3, 0);
    pulse(2, 8'h77);
    checkAll("R11 after stop");

    // R8 sync latency
    pulse(0, 0);
    sendAddr(Me, 1'b0, 1'b1, "R1 match");
    wrByte(8'h00, 1'b1);
    pulse(0, 0);
    sendAddr(Me, 1'b1, 1'b1, "R1 read");
    @(negedge clk);
    ledPins = 4'hA;
    @(negedge clk);
    chk("R8 not yet", txData, 8'h00);
    @(negedge clk);
    chk("R8 visible", txData, 8'h0A);
    rdByte("R8 input read");
    pulse(4, 0);

    // R10 repeated start read at pointer 6 reads zero (R9)
    pulse(0, 0);
    sendAddr(Me, 1'b0, 1'b1, "R1 match");
    wrByte(8'h06, 1'b1);
    pulse(0, 0);
    sendAddr(Me, 1'b1, 1'b1, "R1 read");
    rdByte("R9 read code 6");
    chk("R4 hold no AI", ctrlOut, 8'h06);
    pulse(4, 0);

    // random transfers
    for (int it = 0; it < 300; it++) begin
      int op, n;
      logic [7:0] cb;
      op = $urandom_range(0, 3);
      n  = $urandom_range(0, 6);
      cb = 8'($urandom);
      if (op == 3) begin
        ledPins = 4'($urandom);
        repeat (3) @(negedge clk);
        continue;
      end
      pulse(0, 0);
      sendAddr(Me, 1'b0, 1'b1, "R1 rand");
      wrByte(cb, 1'b1);
      chk("R2 rand ctrl", ctrlOut, cb & 8'h17);
      if (op == 0) begin
        for (int k = 0; k < n; k++) wrByte(8'($urandom), 1'b0);
        checkAll("R3 R4 rand write");
      end else begin
        if (op == 2) pulse(4, 0);
        pulse(0, 0);
        sendAddr(Me, 1'b1, 1'b1, "R1 rand read");
        for (int k = 0; k < n; k++) rdByte("R3 R10 rand read");
        chk("R4 rand ptr", ctrlOut, mCtrl);
      end
      pulse(4, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule